// File: doc/BRIEF.md
# Host/Service Doorbell Mailbox Register Block

This block sits between a host and a service processor and holds the registers the two use to exchange commands. Eight 64-bit mailbox registers carry the traffic: the lower half holds requests written by the host, the upper half holds responses written by the service processor. Two 64-bit doorbell registers signal pending work. The service doorbell tells the service processor that a request is waiting. The host doorbell tells the host that a response is waiting. The top bit of each doorbell drives an interrupt line toward the side that must act.

The host reaches every register through a single-cycle register port. A request is accepted on the clock edge. Read data, a read-valid strobe and an address-error strobe appear one cycle later. They are produced by a small response state machine with the states RSP_IDLE, RSP_DATA, RSP_ERR_RD and RSP_ERR_WR. A request to a decoded address moves the machine to RSP_DATA for a read, or to RSP_IDLE for a write. A request to an undecoded address moves it to RSP_ERR_RD or RSP_ERR_WR. With no request it returns to RSP_IDLE.

The service processor has a write-only port. It may load the response mailboxes and modify either doorbell. Each doorbell can be reached through three addresses: a plain read/write address, an AND address that clears bits, and an OR address that sets bits. When both ports modify one doorbell on the same edge, their masks are merged so that neither update is lost. When both ports write one mailbox on the same edge, the service port wins.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset all mailboxes and both doorbells read as zero, both interrupt outputs are low, and h_rvalid and h_addr_err are low.
- R2: Mailbox i (0 to 7) sits at address 0xD0050+i. A host write stores the data. A host read returns the stored value on h_rdata, with h_rvalid high, exactly one cycle after the request.
- R3: The service doorbell uses addresses 0xD0060 (plain), 0xD0061 (AND) and 0xD0062 (OR). The host doorbell uses 0xD0063 (plain), 0xD0064 (AND) and 0xD0065 (OR). A write to a plain address replaces the doorbell. A read of any of the three addresses returns the current doorbell value.
- R4: A write to an AND address sets the doorbell to its old value ANDed with the write data.
- R5: A write to an OR address sets the doorbell to its old value ORed with the write data.
- R6: irq_svc equals bit 63 of the service doorbell, and irq_host equals bit 63 of the host doorbell. Each changes in the cycle after the write that changes that bit.
- R7: A host access to any address outside the fourteen decoded ones raises h_addr_err for one cycle after the request. A read of such an address returns zero. A write to such an address changes no register.
- R8: The service port can write mailboxes 4 to 7 and all six doorbell addresses. A service write to mailboxes 0 to 3, or to an undecoded address, changes nothing and raises s_addr_err for one cycle after the request.
- R9: When both ports modify the same doorbell on one edge, the new value is (old AND and_h AND and_s) OR or_h OR or_s. A plain write contributes and=0 and or=data. An AND write contributes and=data and or=0. An OR write contributes and=all ones and or=data. A port that is idle contributes and=all ones and or=0.
- R10: When both ports write the same mailbox on one edge, the service data is stored.
- R11: A host read in the same cycle as a service write to that register returns the value from before the write. The next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 20 | Host word address |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, one cycle after the request |
| h_rvalid | output | 1 | Host read data valid |
| h_addr_err | output | 1 | Host access hit an undecoded address |
| s_wr | input | 1 | Service write strobe |
| s_addr | input | 20 | Service word address |
| s_wdata | input | 64 | Service write data |
| s_addr_err | output | 1 | Service write was refused |
| irq_svc | output | 1 | Request-waiting interrupt to the service processor |
| irq_host | output | 1 | Response-waiting interrupt to the host |

## Verification
Two functions can fall in the same cycle: a host change to a doorbell and a service change to that same doorbell, and also a host read and a service write to one register. The bench drives both ports between the same pair of clock edges. It mixes AND with OR, and plain with plain, on one doorbell, and it also targets one shared mailbox. For the doorbell cases it compares the read-back against the merge formula computed from the old value it set up. For the mailbox case it expects the service data to be stored. For the read-during-write case it reads the register in the cycle the service write lands and expects the old value, then reads again and expects the new one.

// File: rtl/mbox_db_pkg.sv
package mbox_db_pkg;
    // Kind of register a decoded address selects
    typedef enum logic [2:0] {
        T_NONE,
        T_MBOX,
        T_DB_RW,
        T_DB_AND,
        T_DB_OR
    } tgt_e;

    // Response phase of the host port
    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_ERR_RD,
        RSP_ERR_WR
    } rsp_e;
endpackage

// File: rtl/mbox_db_decode.sv
module mbox_db_decode
    import mbox_db_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NMBOX = 8,
    parameter logic [ADDR_W-1:0] MBOX_BASE = 20'hD0050,
    parameter logic [ADDR_W-1:0] DB_SVC_BASE = 20'hD0060,
    parameter logic [ADDR_W-1:0] DB_HOST_BASE = 20'hD0063
) (
    input  logic [ADDR_W-1:0]          addr,
    output tgt_e                       tgt,
    output logic                       db_sel,
    output logic [$clog2(NMBOX)-1:0]   idx
);
    localparam int IDX_W = $clog2(NMBOX);
    localparam logic [ADDR_W-1:0] MBOX_END = MBOX_BASE + ADDR_W'(NMBOX);
    localparam logic [1:0][ADDR_W-1:0] DB_BASES = {DB_HOST_BASE, DB_SVC_BASE};

    logic [ADDR_W-1:0] moff;
    logic [ADDR_W-1:0] doff;

    always_comb begin
        tgt    = T_NONE;
        db_sel = 1'b0;
        idx    = '0;
        moff   = addr - MBOX_BASE;
        doff   = '0;
        if (addr >= MBOX_BASE && addr < MBOX_END) begin
            tgt = T_MBOX;
            idx = moff[IDX_W-1:0];
        end else begin
            for (int j = 0; j < 2; j++) begin
                if (addr >= DB_BASES[j] && (addr - DB_BASES[j]) < ADDR_W'(3)) begin
                    doff   = addr - DB_BASES[j];
                    db_sel = 1'(j);
                    unique case (doff[1:0])
                        2'd0:    tgt = T_DB_RW;
                        2'd1:    tgt = T_DB_AND;
                        default: tgt = T_DB_OR;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/mbox_db_doorbell.sv
module mbox_db_doorbell
    import mbox_db_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  tgt_e              h_kind,
    input  logic [DATA_W-1:0] h_data,
    input  logic              s_wr,
    input  tgt_e              s_kind,
    input  logic [DATA_W-1:0] s_data,
    output logic [DATA_W-1:0] q
);
    function automatic logic [DATA_W-1:0] and_mask(logic wr, tgt_e k, logic [DATA_W-1:0] d);
        if (!wr)            return '1;
        if (k == T_DB_RW)   return '0;
        if (k == T_DB_AND)  return d;
        return '1;
    endfunction

    function automatic logic [DATA_W-1:0] or_mask(logic wr, tgt_e k, logic [DATA_W-1:0] d);
        if (wr && (k == T_DB_RW || k == T_DB_OR)) return d;
        return '0;
    endfunction

    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = (q & and_mask(h_wr, h_kind, h_data) & and_mask(s_wr, s_kind, s_data))
              | or_mask(h_wr, h_kind, h_data) | or_mask(s_wr, s_kind, s_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_db_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wr && !s_wr) |=> $stable(q));

    p_db_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_kind == T_DB_AND && !s_wr) |=> ((q & ~$past(h_data)) == '0));

    p_db_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr && s_kind == T_DB_OR && !h_wr) |=> ((q & $past(s_data)) == $past(s_data)));

    p_db_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && s_wr && h_kind == T_DB_OR && s_kind == T_DB_OR)
        |=> ((q & $past(h_data | s_data)) == $past(h_data | s_data)));
endmodule

// File: rtl/mbox_db_mailbox.sv
module mbox_db_mailbox #(
    parameter int DATA_W = 64,
    parameter int NMBOX = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         h_wr,
    input  logic [$clog2(NMBOX)-1:0]     h_idx,
    input  logic [DATA_W-1:0]            h_data,
    input  logic                         s_wr,
    input  logic [$clog2(NMBOX)-1:0]     s_idx,
    input  logic [DATA_W-1:0]            s_data,
    output logic [NMBOX-1:0][DATA_W-1:0] q
);
    localparam int IDX_W = $clog2(NMBOX);

    for (genvar i = 0; i < NMBOX; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                             q[i] <= '0;
            else if (s_wr && s_idx == IDX_W'(i))    q[i] <= s_data;
            else if (h_wr && h_idx == IDX_W'(i))    q[i] <= h_data;
        end

        p_mbox_svc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (h_wr && s_wr && h_idx == IDX_W'(i) && s_idx == IDX_W'(i))
            |=> (q[i] == $past(s_data)));
    end
endmodule

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs
    import mbox_db_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 20,
    parameter int NMBOX = 8,
    parameter logic [ADDR_W-1:0] MBOX_BASE = 20'hD0050,
    parameter logic [ADDR_W-1:0] DB_SVC_BASE = 20'hD0060,
    parameter logic [ADDR_W-1:0] DB_HOST_BASE = 20'hD0063
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_rvalid,
    output logic              h_addr_err,
    input  logic              s_wr,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_addr_err,
    output logic              irq_svc,
    output logic              irq_host
);
    localparam int IDX_W = $clog2(NMBOX);
    localparam int RESP_LO = NMBOX / 2;

    tgt_e             h_tgt, s_tgt;
    logic             h_dsel, s_dsel;
    logic [IDX_W-1:0] h_idx, s_idx;

    mbox_db_decode #(.ADDR_W(ADDR_W), .NMBOX(NMBOX), .MBOX_BASE(MBOX_BASE),
                     .DB_SVC_BASE(DB_SVC_BASE), .DB_HOST_BASE(DB_HOST_BASE))
        u_dec_h (.addr(h_addr), .tgt(h_tgt), .db_sel(h_dsel), .idx(h_idx));

    mbox_db_decode #(.ADDR_W(ADDR_W), .NMBOX(NMBOX), .MBOX_BASE(MBOX_BASE),
                     .DB_SVC_BASE(DB_SVC_BASE), .DB_HOST_BASE(DB_HOST_BASE))
        u_dec_s (.addr(s_addr), .tgt(s_tgt), .db_sel(s_dsel), .idx(s_idx));

    logic h_wr, h_rd, h_is_db, s_is_db, h_mb_wr, s_mb_wr, s_ok;

    always_comb begin
        h_wr    = h_req && h_we;
        h_rd    = h_req && !h_we;
        h_is_db = (h_tgt == T_DB_RW) || (h_tgt == T_DB_AND) || (h_tgt == T_DB_OR);
        s_is_db = (s_tgt == T_DB_RW) || (s_tgt == T_DB_AND) || (s_tgt == T_DB_OR);
        h_mb_wr = h_wr && (h_tgt == T_MBOX);
        s_mb_wr = s_wr && (s_tgt == T_MBOX) && (s_idx >= IDX_W'(RESP_LO));
        s_ok    = s_mb_wr || (s_wr && s_is_db);
    end

    logic [NMBOX-1:0][DATA_W-1:0] mbox_q;
    logic [1:0][DATA_W-1:0]       db_q;

    mbox_db_mailbox #(.DATA_W(DATA_W), .NMBOX(NMBOX)) u_mbox (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_mb_wr), .h_idx(h_idx), .h_data(h_wdata),
        .s_wr(s_mb_wr), .s_idx(s_idx), .s_data(s_wdata),
        .q(mbox_q)
    );

    // index 0: service doorbell, index 1: host doorbell
    for (genvar j = 0; j < 2; j++) begin : g_db
        mbox_db_doorbell #(.DATA_W(DATA_W)) u_db (
            .clk(clk), .rst_n(rst_n),
            .h_wr(h_wr && h_is_db && h_dsel == 1'(j)), .h_kind(h_tgt), .h_data(h_wdata),
            .s_wr(s_wr && s_is_db && s_dsel == 1'(j)), .s_kind(s_tgt), .s_data(s_wdata),
            .q(db_q[j])
        );
    end

    assign irq_svc  = db_q[0][DATA_W-1];
    assign irq_host = db_q[1][DATA_W-1];

    // Host response state machine
    rsp_e              rsp_q, rsp_nxt;
    logic [DATA_W-1:0] rd_val, rdata_q;
    logic              s_err_q;

    always_comb begin
        if (h_tgt == T_MBOX)  rd_val = mbox_q[h_idx];
        else if (h_is_db)     rd_val = db_q[h_dsel];
        else                  rd_val = '0;
        if (!h_req)                rsp_nxt = RSP_IDLE;
        else if (h_tgt == T_NONE)  rsp_nxt = h_we ? RSP_ERR_WR : RSP_ERR_RD;
        else                       rsp_nxt = h_we ? RSP_IDLE : RSP_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            rdata_q <= '0;
            s_err_q <= 1'b0;
        end else begin
            rsp_q   <= rsp_nxt;
            rdata_q <= h_rd ? rd_val : '0;
            s_err_q <= s_wr && !s_ok;
        end
    end

    always_comb begin
        h_rvalid   = 1'b0;
        h_addr_err = 1'b0;
        unique case (rsp_q)
            RSP_IDLE:   ;
            RSP_DATA:   h_rvalid = 1'b1;
            RSP_ERR_RD: begin h_rvalid = 1'b1; h_addr_err = 1'b1; end
            RSP_ERR_WR: h_addr_err = 1'b1;
            default:    ;
        endcase
    end

    assign h_rdata    = rdata_q;
    assign s_addr_err = s_err_q;

    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> h_rvalid);

    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_addr_err |-> (h_rdata == '0));

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_tgt == T_DB_OR && !h_dsel && h_wdata[DATA_W-1]) |=> irq_svc);

    p_svc_lowmbox_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr && s_tgt == T_MBOX && s_idx < IDX_W'(RESP_LO)) |=> s_addr_err);
endmodule

// File: tb/tb_mbox_doorbell_regs.sv
`timescale 1ns/1ps
module tb_mbox_doorbell_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [19:0] h_addr = '0;
    logic [63:0] h_wdata = '0;
    logic [63:0] h_rdata;
    logic        h_rvalid, h_addr_err;
    logic        s_wr = 1'b0;
    logic [19:0] s_addr = '0;
    logic [63:0] s_wdata = '0;
    logic        s_addr_err, irq_svc, irq_host;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mbox_doorbell_regs dut (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_addr_err(h_addr_err),
        .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_addr_err(s_addr_err),
        .irq_svc(irq_svc), .irq_host(irq_host)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [19:0] a, input logic [63:0] d);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic hread(input logic [19:0] a, output logic [63:0] d,
                         output logic v, output logic e);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_addr = a;
        @(negedge clk);
        h_req = 1'b0;
        d = h_rdata; v = h_rvalid; e = h_addr_err;
    endtask

    task automatic swrite(input logic [19:0] a, input logic [63:0] d, output logic e);
        @(negedge clk);
        s_wr = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_wr = 1'b0;
        e = s_addr_err;
    endtask

    task automatic t_reset();
        logic [63:0] d; logic v, e;
        chk("R1 rvalid", {63'd0, h_rvalid}, 64'd0);
        chk("R1 irq", {62'd0, irq_svc, irq_host}, 64'd0);
        hread(20'hD0050, d, v, e); chk("R1 mbox0", d, 64'd0);
        hread(20'hD0057, d, v, e); chk("R1 mbox7", d, 64'd0);
        hread(20'hD0060, d, v, e); chk("R1 dbsvc", d, 64'd0);
        hread(20'hD0063, d, v, e); chk("R1 dbhost", d, 64'd0);
    endtask

    task automatic t_mailbox();
        logic [63:0] d; logic v, e;
        for (int i = 0; i < 8; i++)
            hwrite(20'hD0050 + 20'(i), 64'hA5A5_0000_0000_0000 + 64'(i * 17));
        for (int i = 0; i < 8; i++) begin
            hread(20'hD0050 + 20'(i), d, v, e);
            chk("R2 mbox data", d, 64'hA5A5_0000_0000_0000 + 64'(i * 17));
            chk("R2 rvalid", {62'd0, v, e}, 64'd2);
        end
    endtask

    task automatic t_alias();
        logic [63:0] d; logic v, e;
        hwrite(20'hD0063, 64'h0123_4567_89AB_CDEF);
        hread(20'hD0063, d, v, e); chk("R3 rw read", d, 64'h0123_4567_89AB_CDEF);
        hread(20'hD0064, d, v, e); chk("R3 and-alias read", d, 64'h0123_4567_89AB_CDEF);
        hread(20'hD0065, d, v, e); chk("R3 or-alias read", d, 64'h0123_4567_89AB_CDEF);
        hwrite(20'hD0064, 64'hFFFF_0000_FFFF_0000);
        hread(20'hD0063, d, v, e); chk("R4 and", d, 64'h0123_0000_89AB_0000);
        hwrite(20'hD0065, 64'h8000_0000_0000_00F0);
        hread(20'hD0063, d, v, e); chk("R5 or", d, 64'h8123_0000_89AB_00F0);
        chk("R6 irq_host set", {63'd0, irq_host}, 64'd1);
        swrite(20'hD0064, 64'h7FFF_FFFF_FFFF_FFFF, e);
        chk("R6 irq_host clear", {63'd0, irq_host}, 64'd0);
        chk("R8 svc db ok", {63'd0, e}, 64'd0);
        hwrite(20'hD0062, 64'h8000_0000_0000_0000);
        chk("R6 irq_svc set", {63'd0, irq_svc}, 64'd1);
        chk("R6 irq_host unaffected", {63'd0, irq_host}, 64'd0);
        swrite(20'hD0061, 64'h0, e);
        chk("R6 irq_svc clear", {63'd0, irq_svc}, 64'd0);
    endtask

    task automatic t_bad_addr();
        logic [63:0] d; logic v, e;
        hread(20'hD0058, d, v, e);
        chk("R7 bad read data", d, 64'd0);
        chk("R7 bad read flags", {62'd0, v, e}, 64'd3);
        hread(20'hD004F, d, v, e);
        chk("R7 below base err", {63'd0, e}, 64'd1);
        hwrite(20'hD0063, 64'h55);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = 20'hD0066; h_wdata = 64'hFFFF;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
        chk("R7 bad write err", {62'd0, h_rvalid, h_addr_err}, 64'd1);
        hread(20'hD0063, d, v, e); chk("R7 no side effect", d, 64'h55);
    endtask

    task automatic t_svc_port();
        logic [63:0] d; logic v, e;
        swrite(20'hD0055, 64'hFEED_F00D, e);
        chk("R8 svc mbox5 err", {63'd0, e}, 64'd0);
        hread(20'hD0055, d, v, e); chk("R8 svc mbox5", d, 64'hFEED_F00D);
        hwrite(20'hD0051, 64'h1111);
        swrite(20'hD0051, 64'h2222, e);
        chk("R8 svc low mbox err", {63'd0, e}, 64'd1);
        hread(20'hD0051, d, v, e); chk("R8 low mbox kept", d, 64'h1111);
        swrite(20'hD0070, 64'h3, e);
        chk("R8 svc undecoded err", {63'd0, e}, 64'd1);
    endtask

    task automatic t_concurrent();
        logic [63:0] d; logic v, e;
        hwrite(20'hD0060, 64'hF0F0_F0F0_F0F0_F0F0);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = 20'hD0061; h_wdata = 64'hFF00_FF00_FF00_FF00;
        s_wr = 1'b1; s_addr = 20'hD0062; s_wdata = 64'h0000_0000_0000_000F;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0; s_wr = 1'b0;
        hread(20'hD0060, d, v, e);
        chk("R9 and+or merge", d, 64'hF000_F000_F000_F00F);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = 20'hD0063; h_wdata = 64'h00AA;
        s_wr = 1'b1; s_addr = 20'hD0063; s_wdata = 64'h5500;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0; s_wr = 1'b0;
        hread(20'hD0063, d, v, e);
        chk("R9 rw+rw merge", d, 64'h55AA);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = 20'hD0056; h_wdata = 64'hAAAA;
        s_wr = 1'b1; s_addr = 20'hD0056; s_wdata = 64'hBBBB;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0; s_wr = 1'b0;
        hread(20'hD0056, d, v, e);
        chk("R10 svc wins", d, 64'hBBBB);
    endtask

    task automatic t_rdw();
        logic [63:0] d; logic v, e;
        hwrite(20'hD0057, 64'h0A);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_addr = 20'hD0057;
        s_wr = 1'b1; s_addr = 20'hD0057; s_wdata = 64'h0B;
        @(negedge clk);
        h_req = 1'b0; s_wr = 1'b0;
        chk("R11 old value", h_rdata, 64'h0A);
        hread(20'hD0057, d, v, e);
        chk("R11 new value", d, 64'h0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mailbox();
        t_alias();
        t_bad_addr();
        t_svc_port();
        t_concurrent();
        t_rdw();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule